// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes a core from normal execution into a handler when a fault, a trap, an external interrupt or a single-step event occurs. The enclosing core presents one event on a valid/ready input. The event carries a kind code, an 8-bit vector, the addresses of the current and the next instruction, the privilege mode, and the live stack, flag and code-segment registers. The block then fetches the 64-bit gate descriptor for the vector from the descriptor table through a read port. It pushes the return context onto the proper stack through a write port. Finally it hands the handler's code selector, entry offset, stack segment and stack pointer back on a valid/ready output.

Every stream interface follows the same back-pressure rules. A source that raises valid keeps valid, address and data unchanged until the cycle in which ready is high, and the transfer happens in that cycle. The read response has no ready: the block takes `rsp_valid` in any cycle in which it is waiting for a descriptor. The core presents external interrupts only at instruction boundaries. Event kind codes are 0 fault, 1 trap, 2 external interrupt and 3 single step. The block holds `ev_ready` low from acceptance until the handler result has been taken.

Top module: `exc_entry_seq`

## Requirements
- R1: For a fault (kind 0), the last pushed word (the return address) equals `ev_ip_cur`.
- R2: For a trap (kind 1) or an external interrupt (kind 2), the return address equals `ev_ip_next`.
- R3: A single-step event (kind 3) with flag bit 8 set in `cur_eflags` is handled as a trap on vector 1 with return address `ev_ip_next`. With bit 8 clear it is accepted and dropped: no read, no write, and `busy` stays low.
- R4: With `ev_user` = 1, the block writes five words: zero-extended `cur_ss`, `cur_esp`, `cur_eflags`, zero-extended `cur_cs`, return address. They go in that order to `tss_esp0`-4, -8, -12, -16 and -20. The result carries `hnd_ss` = `tss_ss0` and `hnd_esp` = `tss_esp0`-20.
- R5: With `ev_user` = 0, the block writes three words: `cur_eflags`, zero-extended `cur_cs`, return address. They go to `cur_esp`-4, -8 and -12. The result carries `hnd_ss` = `cur_ss` and `hnd_esp` = `cur_esp`-12.
- R6: The block issues exactly one descriptor read per handled event, at address `dtr[47:16]` + 8 × vector.
- R7: Fields are taken from descriptor `d` as follows. `hnd_off` = {d[63:48], d[15:0]}, `hnd_cs` = d[31:16], `hnd_attr` = d[47:32]. `hnd_vector` is the vector actually used.
- R8: If 8 × vector + 7 exceeds `dtr[15:0]`, the event is replaced by vector 13. The read then goes to base + 104, `hnd_vector` = 13, and the return address is `ev_ip_cur`.
- R9: `busy` is high from the cycle after acceptance until the last write transfer. `ev_ready` is low while `busy` is high and while the result waits. No read or write is pending while the result is offered.
- R10: The read request, the write request and the result each hold valid and payload stable while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be accepted |
| ev_kind | input | 2 | 0 fault, 1 trap, 2 interrupt, 3 single step |
| ev_vector | input | 8 | Requested vector |
| ev_ip_cur | input | 32 | Address of the current instruction |
| ev_ip_next | input | 32 | Address of the next instruction |
| ev_user | input | 1 | Event arrives in user mode |
| cur_cs | input | 16 | Live code selector |
| cur_ss | input | 16 | Live stack selector |
| cur_esp | input | 32 | Live stack pointer |
| cur_eflags | input | 32 | Live flags (bit 8 = single-step) |
| tss_ss0 | input | 16 | Kernel stack selector from the task-state record |
| tss_esp0 | input | 32 | Kernel stack pointer from the task-state record |
| dtr | input | 48 | Table register: base in 47:16, limit in 15:0 |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 32 | Descriptor address |
| rsp_valid | input | 1 | Descriptor data valid |
| rsp_data | input | 64 | Descriptor data |
| wr_valid | output | 1 | Push write request |
| wr_ready | input | 1 | Write taken |
| wr_addr | output | 32 | Push address |
| wr_data | output | 32 | Push data |
| hnd_valid | output | 1 | Handler result valid |
| hnd_ready | input | 1 | Handler result taken |
| hnd_cs | output | 16 | Handler code selector |
| hnd_off | output | 32 | Handler entry offset |
| hnd_attr | output | 16 | Gate type and attribute field |
| hnd_ss | output | 16 | Stack selector after entry |
| hnd_esp | output | 32 | Stack pointer after entry |
| hnd_vector | output | 8 | Vector actually taken |
| busy | output | 1 | Read or push sequence in progress |

## Verification
The hardest case to reach from the ports is a redirected vector that overruns the table limit. It matters most when it lands on a user-mode event of trap or step kind while both memory ports stall, because three rules then interact: the vector changes, the return address switches back to the current instruction, and the stack is switched. The bench sets the limit so that the top 56 vectors overrun. It then sweeps all 256 vectors in both privilege modes, with the kind code and the step flag tied to vector bits, and drives every ready from a pseudo-random sequence. A step event with the flag clear is observed for several cycles at the ports to confirm nothing starts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned DESC_W   = 64;
  localparam int unsigned FRAME_N  = 5;
  localparam int unsigned IDX_W    = $clog2(FRAME_N);
  localparam int unsigned TF_BIT   = 8;
  localparam int unsigned STEP_VEC = 1;

  typedef enum logic [1:0] {
    EK_FAULT = 2'd0,
    EK_TRAP  = 2'd1,
    EK_INTR  = 2'd2,
    EK_STEP  = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_PUSH,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/exc_gate_addr.sv
module exc_gate_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned GP_VEC = 13
) (
  input  logic [ADDR_W+15:0] dtr,
  input  logic [VEC_W-1:0]   vec_in,
  output logic [ADDR_W-1:0]  gate_addr,
  output logic [VEC_W-1:0]   vec_eff,
  output logic               redirect
);
  localparam int unsigned LIM_W = 16;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] limit;
  logic [ADDR_W-1:0] last_byte;

  always_comb begin
    base      = dtr[ADDR_W+LIM_W-1:LIM_W];
    limit     = ADDR_W'(dtr[LIM_W-1:0]);
    last_byte = ADDR_W'({vec_in, 3'b111});
    redirect  = last_byte > limit;
    vec_eff   = redirect ? VEC_W'(GP_VEC) : vec_in;
    gate_addr = base + (ADDR_W'(vec_eff) << 3);
  end
endmodule

// File: rtl/exc_gate_split.sv
module exc_gate_split
  import exc_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] off,
  output logic [15:0]       attr
);
  always_comb begin
    off  = {desc[63:48], desc[15:0]};
    sel  = desc[31:16];
    attr = desc[47:32];
  end
endmodule

// File: rtl/exc_push_seq.sv
module exc_push_seq
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [IDX_W-1:0]          first_idx,
  input  logic [ADDR_W-1:0]         sp_start,
  input  logic [FRAME_N*WORD_W-1:0] words_flat,
  input  logic                      wr_ready,
  output logic                      wr_valid,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [WORD_W-1:0]         wr_data,
  output logic                      done
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_N - 1);
  localparam logic [ADDR_W-1:0] SLOT_B   = ADDR_W'(WORD_W / 8);

  logic [WORD_W-1:0] word_arr [FRAME_N];
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] sp_q;

  for (genvar g = 0; g < FRAME_N; g++) begin : g_unpack
    assign word_arr[g] = words_flat[g*WORD_W +: WORD_W];
  end

  always_comb begin
    wr_data = '0;
    for (int i = 0; i < FRAME_N; i++) begin
      if (idx_q == IDX_W'(i)) wr_data = word_arr[i];
    end
  end

  assign wr_valid = active_q;
  assign wr_addr  = sp_q;
  assign done     = active_q && wr_ready && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sp_q     <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= first_idx;
      sp_q     <= sp_start - SLOT_B;
    end else if (active_q && wr_ready) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        sp_q  <= sp_q - SLOT_B;
      end
    end
  end

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_wr_descend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !done |=> wr_valid && (wr_addr == $past(wr_addr) - SLOT_B));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !start);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned GP_VEC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic [VEC_W-1:0]  ev_vector,
  input  logic [ADDR_W-1:0] ev_ip_cur,
  input  logic [ADDR_W-1:0] ev_ip_next,
  input  logic              ev_user,
  input  logic [15:0]       cur_cs,
  input  logic [15:0]       cur_ss,
  input  logic [ADDR_W-1:0] cur_esp,
  input  logic [31:0]       cur_eflags,
  input  logic [15:0]       tss_ss0,
  input  logic [ADDR_W-1:0] tss_esp0,
  input  logic [ADDR_W+15:0] dtr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              hnd_valid,
  input  logic              hnd_ready,
  output logic [15:0]       hnd_cs,
  output logic [31:0]       hnd_off,
  output logic [15:0]       hnd_attr,
  output logic [15:0]       hnd_ss,
  output logic [ADDR_W-1:0] hnd_esp,
  output logic [VEC_W-1:0]  hnd_vector,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] SLOT_B   = ADDR_W'(WORD_W / 8);
  localparam logic [IDX_W-1:0]  USER_IDX = '0;
  localparam logic [IDX_W-1:0]  KERN_IDX = IDX_W'(2);

  seq_state_e state_q;
  ev_kind_e   kind_in;

  logic              accept, step_ev, step_drop;
  logic [VEC_W-1:0]  vec_req, vec_eff;
  logic [ADDR_W-1:0] gate_addr;
  logic              redirect;
  logic [WORD_W-1:0] ret_ip;

  logic [ADDR_W-1:0]         gate_addr_q;
  logic [VEC_W-1:0]          vec_q;
  logic                      user_q;
  logic [ADDR_W-1:0]         sp_start_q;
  logic [ADDR_W-1:0]         esp_end_q;
  logic [15:0]               ss_q;
  logic [FRAME_N*WORD_W-1:0] frame_q;
  logic [DESC_W-1:0]         desc_q;

  logic push_start, push_done;

  assign kind_in   = ev_kind_e'(ev_kind);
  assign ev_ready  = (state_q == ST_IDLE);
  assign accept    = ev_valid && ev_ready;
  assign step_ev   = (kind_in == EK_STEP);
  assign step_drop = step_ev && !cur_eflags[TF_BIT];
  assign vec_req   = step_ev ? VEC_W'(STEP_VEC) : ev_vector;
  assign ret_ip    = ((kind_in == EK_FAULT) || redirect) ? WORD_W'(ev_ip_cur) : WORD_W'(ev_ip_next);

  exc_gate_addr #(
    .ADDR_W (ADDR_W),
    .VEC_W  (VEC_W),
    .GP_VEC (GP_VEC)
  ) i_gate_addr (
    .dtr       (dtr),
    .vec_in    (vec_req),
    .gate_addr (gate_addr),
    .vec_eff   (vec_eff),
    .redirect  (redirect)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      gate_addr_q <= '0;
      vec_q       <= '0;
      user_q      <= 1'b0;
      sp_start_q  <= '0;
      esp_end_q   <= '0;
      ss_q        <= '0;
      frame_q     <= '0;
      desc_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept && !step_drop) begin
            state_q     <= ST_RDREQ;
            gate_addr_q <= gate_addr;
            vec_q       <= vec_eff;
            user_q      <= ev_user;
            sp_start_q  <= ev_user ? tss_esp0 : cur_esp;
            esp_end_q   <= ev_user ? (tss_esp0 - SLOT_B * ADDR_W'(5))
                                   : (cur_esp - SLOT_B * ADDR_W'(3));
            ss_q        <= ev_user ? tss_ss0 : cur_ss;
            frame_q     <= {ret_ip,
                            WORD_W'(cur_cs),
                            WORD_W'(cur_eflags),
                            WORD_W'(cur_esp),
                            WORD_W'(cur_ss)};
          end
        end
        ST_RDREQ:  if (rd_ready) state_q <= ST_RDWAIT;
        ST_RDWAIT: begin
          if (rsp_valid) begin
            desc_q  <= rsp_data;
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH:   if (push_done) state_q <= ST_DONE;
        ST_DONE:   if (hnd_ready) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_start = (state_q == ST_RDWAIT) && rsp_valid;
  assign rd_valid   = (state_q == ST_RDREQ);
  assign rd_addr    = gate_addr_q;
  assign busy       = (state_q == ST_RDREQ) || (state_q == ST_RDWAIT) || (state_q == ST_PUSH);
  assign hnd_valid  = (state_q == ST_DONE);
  assign hnd_ss     = ss_q;
  assign hnd_esp    = esp_end_q;
  assign hnd_vector = vec_q;

  exc_push_seq #(
    .ADDR_W (ADDR_W)
  ) i_push (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (push_start),
    .first_idx  (user_q ? USER_IDX : KERN_IDX),
    .sp_start   (sp_start_q),
    .words_flat (frame_q),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (push_done)
  );

  exc_gate_split i_split (
    .desc (desc_q),
    .sel  (hnd_cs),
    .off  (hnd_off),
    .attr (hnd_attr)
  );

  p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_ready);

  p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid |-> !busy && !wr_valid && !rd_valid && !ev_ready);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_hnd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hnd_valid && !hnd_ready |=> hnd_valid && $stable(hnd_cs) && $stable(hnd_off) && $stable(hnd_esp));

  p_step_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && step_drop |=> !busy && !rd_valid && ev_ready);

  p_gp_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !step_drop && redirect |=> hnd_vector == VEC_W'(GP_VEC));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int AW = 32;
  localparam int VW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          ev_valid = 1'b0, ev_ready, ev_user = 1'b0;
  logic [1:0]    ev_kind = '0;
  logic [VW-1:0] ev_vector = '0;
  logic [31:0]   ev_ip_cur = '0, ev_ip_next = '0, cur_esp = '0, cur_eflags = '0, tss_esp0 = '0;
  logic [15:0]   cur_cs = '0, cur_ss = '0, tss_ss0 = '0;
  logic [47:0]   dtr = '0;
  logic          rd_valid, rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0]   rd_addr;
  logic [63:0]   rsp_data = '0;
  logic          wr_valid, wr_ready = 1'b0;
  logic [31:0]   wr_addr, wr_data;
  logic          hnd_valid, hnd_ready = 1'b0, busy;
  logic [15:0]   hnd_cs, hnd_attr, hnd_ss;
  logic [31:0]   hnd_off, hnd_esp;
  logic [VW-1:0] hnd_vector;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
    .ev_vector(ev_vector), .ev_ip_cur(ev_ip_cur), .ev_ip_next(ev_ip_next), .ev_user(ev_user),
    .cur_cs(cur_cs), .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eflags(cur_eflags),
    .tss_ss0(tss_ss0), .tss_esp0(tss_esp0), .dtr(dtr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .hnd_valid(hnd_valid),
    .hnd_ready(hnd_ready), .hnd_cs(hnd_cs), .hnd_off(hnd_off), .hnd_attr(hnd_attr),
    .hnd_ss(hnd_ss), .hnd_esp(hnd_esp), .hnd_vector(hnd_vector), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] desc_of(input logic [7:0] v);
    return {8'hC0, v, 16'h8E00 ^ {8'h00, v}, 8'h08, v, 8'h30, ~v};
  endfunction

  // memory and sink model
  logic [31:0] lfsr = 32'h1ACE_B00C;
  bit          bp_en = 0;
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  int          rn = 0, wn = 0;
  logic [31:0] ra = '0;
  logic [31:0] wa [8];
  logic [31:0] wd [8];
  bit          hseen = 0;
  logic [15:0] h_cs, h_attr, h_ss;
  logic [31:0] h_off, h_esp;
  logic [7:0]  h_vec;

  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    rd_ready  = bp_en ? lfsr[3] : 1'b1;
    wr_ready  = bp_en ? lfsr[7] : 1'b1;
    hnd_ready = bp_en ? lfsr[12] : 1'b1;
    if (pend) begin
      rsp_valid = 1'b1;
      rsp_data  = desc_of(8'((pend_addr - dtr[47:16]) >> 3));
      pend      = 0;
    end else begin
      rsp_valid = 1'b0;
    end
    if (rd_valid && rd_ready) begin
      pend = 1; pend_addr = rd_addr; rn++; ra = rd_addr;
    end
    if (wr_valid && wr_ready) begin
      if (wn < 8) begin wa[wn] = wr_addr; wd[wn] = wr_data; end
      wn++;
    end
    if (hnd_valid && hnd_ready && !hseen) begin
      hseen = 1; h_cs = hnd_cs; h_off = hnd_off; h_attr = hnd_attr;
      h_ss = hnd_ss; h_esp = hnd_esp; h_vec = hnd_vector;
    end
  end

  task automatic run_ev(input logic [1:0] kind, input logic [7:0] v, input bit user,
                        input logic [31:0] flags);
    bit          drop, redir;
    logic [7:0]  rv, evv;
    logic [31:0] ret, sp0, ex_w [5];
    int          n, first;
    logic [63:0] d;
    @(negedge clk);
    ev_kind = kind; ev_vector = v; ev_user = user; cur_eflags = flags;
    ev_ip_cur  = 32'h4000_0000 + 32'(v) * 3;
    ev_ip_next = ev_ip_cur + 32'(v % 5) + 1;
    cur_cs = 16'h0023 + 16'(v); cur_ss = 16'h002B ^ 16'(v);
    cur_esp = 32'h0008_0000 + 32'(v) * 16; tss_ss0 = 16'h0018; tss_esp0 = 32'h0009_0000 - 32'(v) * 4;
    rn = 0; wn = 0; hseen = 0;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    drop = (kind == 2'd3) && !flags[8];
    if (drop) begin
      for (int k = 0; k < 6; k++) begin
        chk(!busy && ev_ready && rn == 0 && wn == 0, "R3", "dropped step started work",
            {busy, ev_ready, 8'(rn), 8'(wn)}, {1'b0, 1'b1, 16'h0});
        @(negedge clk);
      end
      return;
    end
    chk(busy && !ev_ready, "R9", "busy after accept", {busy, ev_ready}, 2'b10);
    while (!hseen) @(negedge clk);
    @(negedge clk);
    chk(!busy && ev_ready, "R9", "idle after result", {busy, ev_ready}, 2'b01);
    rv    = (kind == 2'd3) ? 8'd1 : v;
    redir = (32'(rv) * 8 + 7) > 32'(dtr[15:0]);
    evv   = redir ? 8'd13 : rv;
    ret   = (kind == 2'd0 || redir) ? ev_ip_cur : ev_ip_next;
    chk(rn == 1 && ra == dtr[47:16] + 32'(evv) * 8, redir ? "R8" : "R6", "gate read",
        {32'(rn), ra}, {32'd1, dtr[47:16] + 32'(evv) * 8});
    ex_w[0] = {16'h0, cur_ss}; ex_w[1] = cur_esp; ex_w[2] = flags;
    ex_w[3] = {16'h0, cur_cs}; ex_w[4] = ret;
    n     = user ? 5 : 3;
    first = 5 - n;
    sp0   = user ? tss_esp0 : cur_esp;
    chk(wn == n, user ? "R4" : "R5", "push count", 64'(wn), 64'(n));
    for (int k = 0; k < n && k < 8; k++) begin
      if (k == n - 1)
        chk(wa[k] == sp0 - 32'(4 * (k + 1)) && wd[k] == ret,
            kind == 2'd0 ? "R1" : (redir ? "R8" : (kind == 2'd3 ? "R3" : "R2")),
            "return address push", {wa[k], wd[k]}, {sp0 - 32'(4 * (k + 1)), ret});
      else
        chk(wa[k] == sp0 - 32'(4 * (k + 1)) && wd[k] == ex_w[first + k], user ? "R4" : "R5",
            "context push", {wa[k], wd[k]}, {sp0 - 32'(4 * (k + 1)), ex_w[first + k]});
    end
    d = desc_of(evv);
    chk(h_off == {d[63:48], d[15:0]} && h_cs == d[31:16] && h_attr == d[47:32] && h_vec == evv,
        "R7", "handler fields", {h_off, h_cs, h_vec, 8'h0},
        {d[63:48], d[15:0], d[31:16], evv, 8'h0});
    chk(h_ss == (user ? tss_ss0 : cur_ss) && h_esp == sp0 - 32'(4 * n), user ? "R4" : "R5",
        "handler stack", {h_ss, h_esp}, {(user ? tss_ss0 : cur_ss), sp0 - 32'(4 * n)});
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    dtr = {32'h0010_0000, 16'd1599};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_ready && !busy && !rd_valid && !wr_valid && !hnd_valid, "R9", "reset state",
        {ev_ready, busy, rd_valid, wr_valid, hnd_valid}, 5'b10000);
    // sweep every vector in both modes; kind and step flag follow vector bits
    for (int u = 0; u < 2; u++) begin
      for (int v = 0; v < 256; v++) begin
        bp_en = (v % 3) != 0;
        run_ev(2'((v >> 1) & 3), 8'(v), u[0], 32'h0000_0202 | (v[2] ? 32'h100 : 32'h0) | 32'(v << 12));
      end
    end
    // corner: step with flag clear in user mode, then set, under back-pressure
    bp_en = 1;
    run_ev(2'd3, 8'd77, 1'b1, 32'h0000_0002);
    run_ev(2'd3, 8'd77, 1'b1, 32'h0000_0102);
    // corner: limit exactly covering vector 13 only
    dtr = {32'h0020_0000, 16'd111};
    run_ev(2'd1, 8'd14, 1'b1, 32'h0000_0202);
    run_ev(2'd2, 8'd13, 1'b0, 32'h0000_0202);
    run_ev(2'd0, 8'd0, 1'b0, 32'h0000_0202);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule